// File: doc/BRIEF.md
# Page Write Collector and Self-Timed Commit Sequencer

This block sits behind the serial protocol engine of a small byte-addressed non-volatile store. When a write transaction opens, the engine hands over the word address that followed the control byte, then streams each received data byte over a valid/ready channel. The bytes go into a page latch of `PAGE_BYTES` slots, each with its own valid bit. Nothing touches the array while the transaction is open. Each accepted byte moves the slot index forward by one. The index wraps inside the page, so the page base never changes and an overflow overwrites the oldest slots in arrival order.

A stop strobe that follows at least one byte, with the protect input low, starts a self-timed write period of `WRITE_TICKS` clock cycles. During the first `PAGE_BYTES` cycles of that period, the block issues one array write strobe for each valid slot, in ascending slot order. Slots that were never filled are skipped and keep their old contents. Throughout the period `busy` stays high. The protocol engine uses it to withhold acknowledges, which lets a master poll for completion. A repeated start, a stop with no data, or a stop with protection high discards the latch and starts no write period.

The block also owns the shared address pointer. Loading a word address sets the pointer to that address. A completed write period leaves the pointer at the last address written, so the read path can fetch the location that follows.

Top module: `page_write_seq`

## Requirements
- R1: After reset, `busy` is 0, `byte_ready` is 1, `mem_we` is 0 and `addr_ptr` is 0.
- R2: A byte transfers on a cycle where `byte_valid` and `byte_ready` are both 1. `byte_ready` is 0 for the whole write period, and a byte offered then is not stored: a later stop with no new bytes starts no write period.
- R3: `mem_we` stays 0 while bytes are being collected and before the stop strobe.
- R4: Each accepted byte goes to slot index (`addr_in[IDX_W-1:0]` + n) mod `PAGE_BYTES`, where n counts earlier bytes in the transaction. The upper address bits do not change. When several bytes land in one slot, the latest one is kept.
- R5: A stop while idle, with at least one byte held and `wp` at 0, raises `busy` on the next cycle and holds it for exactly `WRITE_TICKS` cycles.
- R6: During the first `PAGE_BYTES` cycles of the write period, `mem_we` pulses once for each valid slot, in ascending slot order. Each pulse carries `mem_addr` = {page base, slot} and that slot's latest byte. Slots without a valid bit get no pulse.
- R7: A stop with no byte held starts no write period and issues no strobe.
- R8: With `wp` at 1 at the stop, bytes are still accepted, but no write period starts and no strobe is issued.
- R9: A `restart` before the stop discards the held bytes. No write period follows, and a later stop with no new bytes also starts none.
- R10: `addr_load` sets `addr_ptr` to `addr_in` on the next cycle. When a write period ends, `addr_ptr` holds the address of the last accepted byte.
- R11: `addr_load`, `stop` and `restart` have no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Load word address and open a new page |
| addr_in | input | ADDR_W | Starting word address |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Data byte can be taken (low while busy) |
| byte_data | input | DATA_W | Data byte |
| stop | input | 1 | Stop condition seen on the bus |
| restart | input | 1 | Repeated start seen before stop |
| wp | input | 1 | Write protect, 1 blocks programming |
| busy | output | 1 | Write period in progress, suppress acknowledges |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| addr_ptr | output | ADDR_W | Shared address pointer |

## Verification
The bench builds the block with the default 8-byte page and 8-bit addresses, but shortens `WRITE_TICKS` to 20 cycles. At that length every write period can be counted edge to edge, and hundreds of transactions fit in the run. It drives random transactions: random start addresses, bursts of 0 to 13 bytes so that rollover past a full page happens often, protection on about a quarter of the time, and an occasional repeated start. Directed cases cover an 11-byte wrap at a mid-page start, a stop on an empty page, protected writes, and attempts to load, stop or feed bytes during a write period.

// File: rtl/page_write_pkg.sv
package page_write_pkg;
  function automatic int unsigned idx_width(input int unsigned slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction
endpackage

// File: rtl/page_latch.sv
module page_latch #(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IW    = page_write_pkg::idx_width(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [SLOTS-1:0]  mask
);
  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
        mask[s]   <= 1'b0;
      end else if (clr) begin
        mask[s]   <= 1'b0;
      end else if (wr_en && wr_idx == IW'(s)) begin
        slot_q[s] <= wr_data;
        mask[s]   <= 1'b1;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mask == '0));
endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int unsigned TICKS = 2000000,
  localparam int unsigned CW   = $clog2(TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [CW-1:0] count,
  output logic          done
);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  assign done = active && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      count  <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        count  <= '0;
      end
    end else if (done) begin
      active <= 1'b0;
      count  <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

  assert_starts_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (count == '0));
  assert_keeps_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && count != LAST) |=> active);
  assert_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (count <= LAST));
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PAGE_BYTES  = 8,
  parameter int unsigned WRITE_TICKS = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  input  logic              restart,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] addr_ptr
);
  localparam int unsigned IDX_W  = page_write_pkg::idx_width(PAGE_BYTES);
  localparam int unsigned PAGE_W = ADDR_W - IDX_W;
  localparam int unsigned CNT_W  = $clog2(WRITE_TICKS + 1);
  localparam logic [CNT_W-1:0] COMMIT_END = CNT_W'(PAGE_BYTES);

  logic [PAGE_W-1:0]     page_q;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      last_q;
  logic [ADDR_W-1:0]     ptr_q;
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     slot_data;
  logic [CNT_W-1:0]      tick;
  logic                  timer_done;
  logic                  take_byte;
  logic                  commit_go;
  logic                  clear_page;
  logic [IDX_W-1:0]      scan_idx;
  logic                  in_commit;

  assign byte_ready = !busy;
  assign take_byte  = byte_valid && byte_ready;
  assign commit_go  = stop && !busy && !wp && (mask != '0);
  assign clear_page = (!busy && (restart || stop || addr_load) && !commit_go) || timer_done;

  assign scan_idx  = tick[IDX_W-1:0];
  assign in_commit = busy && (tick < COMMIT_END);
  assign mem_we    = in_commit && mask[scan_idx];
  assign mem_addr  = {page_q, scan_idx};
  assign mem_wdata = slot_data;
  assign addr_ptr  = ptr_q;

  page_latch #(.SLOTS(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clear_page),
    .wr_en   (take_byte),
    .wr_idx  (idx_q),
    .wr_data (byte_data),
    .rd_idx  (scan_idx),
    .rd_data (slot_data),
    .mask    (mask)
  );

  cycle_timer #(.TICKS(WRITE_TICKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (commit_go),
    .active (busy),
    .count  (tick),
    .done   (timer_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      idx_q  <= '0;
      last_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (!busy && addr_load) begin
        page_q <= addr_in[ADDR_W-1:IDX_W];
        idx_q  <= addr_in[IDX_W-1:0];
        ptr_q  <= addr_in;
      end else if (take_byte) begin
        last_q <= idx_q;
        idx_q  <= idx_q + 1'b1;
      end
      if (timer_done) begin
        ptr_q <= {page_q, last_q};
      end
    end
  end

  assert_index_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_byte && !addr_load) |=> (idx_q == $past(idx_q) + 1'b1) && $stable(page_q));
  assert_strobe_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:IDX_W] == page_q) && $stable(page_q));
  assert_empty_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && mask == '0) |=> !busy);
  assert_protect_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !busy && wp) |=> !busy);
  assert_restart_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !stop && !busy) |=> !busy);
  assert_ptr_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (addr_ptr == {page_q, last_q}));
  assert_busy_holds_ptr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !timer_done) |=> $stable(addr_ptr) && $stable(page_q));
endmodule

// File: tb/page_write_seq_bench.sv
module page_write_seq_bench;
  localparam int WT = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load = 0, byte_valid = 0, stop = 0, restart = 0, wp = 0;
  logic [7:0] addr_in = 0, byte_data = 0;
  logic byte_ready, busy, mem_we;
  logic [7:0] mem_addr, mem_wdata, addr_ptr;

  int checks = 0, fails = 0;
  int log_n = 0, busy_n = 0;
  logic [7:0] log_a [64];
  logic [7:0] log_d [64];
  bit finished = 0;

  always #2.5 clk = ~clk;

  page_write_seq #(.ADDR_W(8), .DATA_W(8), .PAGE_BYTES(8), .WRITE_TICKS(WT)) u_page_write_seq (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .stop(stop), .restart(restart), .wp(wp), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .addr_ptr(addr_ptr));

  always @(negedge clk) begin
    if (busy) busy_n++;
    if (mem_we) begin
      if (log_n < 64) begin
        log_a[log_n] = mem_addr;
        log_d[log_n] = mem_wdata;
      end
      log_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slot_addr(input logic [7:0] base, input int n);
    return {base[7:3], 3'(base[2:0] + 3'(n))};
  endfunction

  task automatic run_txn(input logic [7:0] a, input int n, input logic w, input logic rs);
    logic [7:0] ed [8];
    bit em [8];
    int k;
    bit commit;
    for (int s = 0; s < 8; s++) em[s] = 0;
    @(negedge clk);
    log_n = 0; busy_n = 0;
    wp = w; addr_in = a; addr_load = 1;
    @(negedge clk);
    addr_load = 0;
    chk("R10 load ptr", addr_ptr, a);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      byte_valid = 1; byte_data = d;
      ed[3'(a[2:0] + 3'(i))] = d;
      em[3'(a[2:0] + 3'(i))] = 1;
      @(negedge clk);
    end
    byte_valid = 0;
    chk("R3 no early write", log_n, 0);
    if (rs) restart = 1; else stop = 1;
    @(negedge clk);
    stop = 0; restart = 0;
    repeat (WT + 4) @(negedge clk);
    commit = !rs && n > 0 && !w;
    if (rs) chk("R9 restart busy", busy_n, 0);
    else if (w) chk("R8 protect busy", busy_n, 0);
    else if (n == 0) chk("R7 empty busy", busy_n, 0);
    else chk("R5 busy length", busy_n, WT);
    k = 0;
    for (int s = 0; s < 8; s++) begin
      if (commit && em[s]) begin
        if (k < log_n) begin
          chk("R6 strobe addr", log_a[k], {a[7:3], 3'(s)});
          chk("R4 strobe data", log_d[k], ed[s]);
        end
        k++;
      end
    end
    chk("R6 strobe count", log_n, k);
    chk("R10 final ptr", addr_ptr, commit ? slot_addr(a, n - 1) : a);
  endtask

  initial begin
    #(5 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 ready", byte_ready, 1);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 ptr", addr_ptr, 0);

    run_txn(8'h45, 11, 0, 0);
    run_txn(8'h10, 1, 0, 0);
    run_txn(8'hF8, 8, 0, 0);
    run_txn(8'h33, 0, 0, 0);
    run_txn(8'h62, 5, 1, 0);
    run_txn(8'h97, 4, 0, 1);

    // R9: stop after a discarded page starts nothing
    @(negedge clk); log_n = 0; busy_n = 0; stop = 1;
    @(negedge clk); stop = 0;
    repeat (WT + 2) @(negedge clk);
    chk("R9 stop after restart", busy_n, 0);

    // R2 / R11: activity during the write period
    run_txn(8'hA1, 0, 0, 0);
    @(negedge clk); addr_in = 8'hA1; addr_load = 1;
    @(negedge clk); addr_load = 0; byte_valid = 1; byte_data = 8'h5A;
    @(negedge clk); byte_valid = 0; stop = 1;
    @(negedge clk); stop = 0;
    chk("R5 busy raised", busy, 1);
    for (int i = 0; i < 5; i++) begin
      byte_valid = 1; byte_data = 8'hEE; addr_load = 1; addr_in = 8'h07;
      restart = 1;
      @(negedge clk);
      chk("R2 ready low", byte_ready, 0);
    end
    byte_valid = 0; addr_load = 0; restart = 0;
    repeat (WT) @(negedge clk);
    chk("R11 ptr kept", addr_ptr, 8'hA1);
    log_n = 0; busy_n = 0; stop = 1;
    @(negedge clk); stop = 0;
    repeat (WT + 2) @(negedge clk);
    chk("R2 busy bytes dropped", busy_n, 0);

    for (int t = 0; t < 200; t++) begin
      run_txn(8'($urandom), int'($urandom_range(0, 13)),
              ($urandom_range(0, 3) == 0), ($urandom_range(0, 4) == 0));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule